// File: doc/BRIEF.md
# Powered-Device Port Voltage Sequencer

This block watches the sampled voltage on a Power-over-Ethernet port and decides which powered-device function should be active. It drives four outputs: an enable for the detection signature, an enable for the classification current, a 2-bit class request, and a power-good flag that releases the downstream inrush and hotswap logic. The voltage input is a code at 10 mV per LSB. The block also takes a die temperature code in whole degrees Celsius and a 2-bit class selection that comes from board straps.

Each voltage sample is first sorted into one of eight zones. The zone boundaries are the detection window, the classification window, the power-on and power-off levels, and the reset level. A new zone is accepted only after a set number of consecutive samples agree on it. All output decisions are made from this filtered zone.

The block supports only a single classification event. Once the port has been in the class window and left it, a later return to the class window draws no current. This lasts until the port falls to the reset level. Power-good has separate rising and falling thresholds, and a thermal override with its own hysteresis can force it low.

Top module: `pd_line_seq`

## Requirements
- R1: While reset is asserted, and right after it is released with a port code of 0, every output is 0.
- R2: `sig_en` is 1 exactly while the filtered port code lies in 270..1010 (2.70 V to 10.10 V inclusive) and power-good is low.
- R3: `cls_en` is 1 while the filtered port code lies in 1450..2140 (14.50 V to 21.40 V inclusive), power-good is low, and no earlier class event has ended since the last reset-level visit.
- R4: `cls_code` gives the class request: 0 asks for 0-4 mA, 1 for 9-12 mA, 2 for 17-20 mA and 3 for 26-30 mA. Its value is `class_sel` as sampled on the clock edge that enters the class window. Later changes of `class_sel` during that event have no effect. `cls_code` is 0 whenever `cls_en` is 0.
- R5: `pwr_good` rises when the filtered code reaches 3700 (37.00 V) or more. It falls only when the filtered code drops below 3200 (32.00 V).
- R6: Suppose the port leaves the class window, for example by dipping to a mark level near 10 V, and then rises back into the class window. That second entry leaves `cls_en` and `cls_code` at 0.
- R7: A die temperature above 160 forces `pwr_good` low within two clock edges. The override clears only once the temperature is 140 or lower.
- R8: A filtered port code below 160 (1.60 V) returns the sequencer to its reset state. This clears the class-event memory, so a new class event is answered again.
- R9: A new zone takes effect on the FILT_N-th consecutive clock edge that samples it. An excursion lasting FILT_N-1 samples changes no output.
- R10: `sig_en` and `cls_en` are never 1 together, and both are 0 while `pwr_good` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_mv | input | VW (13) | Port voltage code, 10 mV per LSB |
| die_temp | input | TW (8) | Die temperature, degrees Celsius, unsigned |
| class_sel | input | 2 | Strapped class selection |
| sig_en | output | 1 | Detection signature enable |
| cls_en | output | 1 | Classification current enable |
| cls_code | output | 2 | Encoded class current request |
| pwr_good | output | 1 | Power-good, enables hotswap logic |

## Verification
The port code is swept across each window edge one LSB on either side. This separates inclusive boundaries from exclusive ones for detection, classification and reset. A climb to 37 V followed by descents that stop at 32.00 V, 31.99 V and 35 V separates true hysteresis from a single threshold. A sequence of class, mark dip, class, reset dip, class distinguishes one-event behaviour from re-arming. Short excursions of FILT_N-1 samples, compared against full FILT_N holds, pin down the exact filter depth. Thermal steps to 160, 161, 150 and 140 show where the override engages and where it releases.

// File: rtl/pd_line_seq.sv
module pd_line_seq #(
  parameter int VW      = 13,
  parameter int TW      = 8,
  parameter int FILT_N  = 4,
  parameter int RST_LV  = 160,
  parameter int DET_LO  = 270,
  parameter int DET_HI  = 1010,
  parameter int CLS_LO  = 1450,
  parameter int CLS_HI  = 2140,
  parameter int PG_OFF  = 3200,
  parameter int PG_ON   = 3700,
  parameter int T_HOT   = 160,
  parameter int T_HYST  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] port_mv,
  input  logic [TW-1:0] die_temp,
  input  logic [1:0]    class_sel,
  output logic          sig_en,
  output logic          cls_en,
  output logic [1:0]    cls_code,
  output logic          pwr_good
);
  localparam int CW = $clog2(FILT_N + 1);
  localparam logic [CW:0]    N_W    = (CW+1)'(FILT_N);
  localparam logic [VW-1:0]  V_RST  = VW'(RST_LV);
  localparam logic [VW-1:0]  V_DLO  = VW'(DET_LO);
  localparam logic [VW-1:0]  V_DHI  = VW'(DET_HI);
  localparam logic [VW-1:0]  V_CLO  = VW'(CLS_LO);
  localparam logic [VW-1:0]  V_CHI  = VW'(CLS_HI);
  localparam logic [VW-1:0]  V_POFF = VW'(PG_OFF);
  localparam logic [VW-1:0]  V_PON  = VW'(PG_ON);
  localparam logic [TW-1:0]  T_SET  = TW'(T_HOT);
  localparam logic [TW-1:0]  T_CLR  = TW'(T_HOT - T_HYST);

  localparam logic [2:0] Z_RST = 3'd0, Z_DET = 3'd2, Z_CLS = 3'd4,
                         Z_HYS = 3'd6, Z_PON = 3'd7;

  logic [2:0]  raw_z, cand, fz;
  logic [CW:0] cnt, agree;
  logic        hot_q, pg_q, spent_q, in_cls_q;
  logic [1:0]  code_q;

  always_comb begin
    if      (port_mv <  V_RST)  raw_z = 3'd0;
    else if (port_mv <  V_DLO)  raw_z = 3'd1;
    else if (port_mv <= V_DHI)  raw_z = 3'd2;
    else if (port_mv <  V_CLO)  raw_z = 3'd3;
    else if (port_mv <= V_CHI)  raw_z = 3'd4;
    else if (port_mv <  V_POFF) raw_z = 3'd5;
    else if (port_mv <  V_PON)  raw_z = 3'd6;
    else                        raw_z = 3'd7;
  end

  assign agree = (raw_z == cand) ? cnt + 1'b1 : (CW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= Z_RST;
      cnt  <= '0;
      fz   <= Z_RST;
    end else begin
      cand <= raw_z;
      cnt  <= (agree >= N_W) ? N_W : agree;
      if (agree >= N_W) fz <= raw_z;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q    <= 1'b0;
      pg_q     <= 1'b0;
      spent_q  <= 1'b0;
      in_cls_q <= 1'b0;
      code_q   <= 2'd0;
    end else begin
      if (die_temp > T_SET)       hot_q <= 1'b1;
      else if (die_temp <= T_CLR) hot_q <= 1'b0;

      if (hot_q || fz < Z_HYS) pg_q <= 1'b0;
      else if (fz == Z_PON)    pg_q <= 1'b1;

      in_cls_q <= (fz == Z_CLS);
      if (fz == Z_RST)                    spent_q <= 1'b0;
      else if (in_cls_q && fz != Z_CLS)   spent_q <= 1'b1;

      if (fz != Z_CLS) code_q <= class_sel;
    end
  end

  assign pwr_good = pg_q;
  assign sig_en   = (fz == Z_DET) && !pg_q;
  assign cls_en   = (fz == Z_CLS) && !spent_q && !pg_q;
  assign cls_code = cls_en ? code_q : 2'd0;
endmodule

// File: rtl/pd_line_seq_chk.sv
module pd_line_seq_chk #(
  parameter int TW    = 8,
  parameter int T_HOT = 160
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] die_temp,
  input logic          sig_en,
  input logic          cls_en,
  input logic [1:0]    cls_code,
  input logic          pwr_good,
  input logic [2:0]    filt_zone,
  input logic          hot
);
  localparam logic [TW-1:0] T_SET = TW'(T_HOT);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sig_en && cls_en));
  a_r10_pg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good |-> (!sig_en && !cls_en));
  a_r4_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cls_en |-> cls_code == 2'd0);
  a_r4_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_en && $past(cls_en)) |-> $stable(cls_code));
  a_r2_det_zone: assert property (@(posedge clk) disable iff (!rst_n)
    sig_en |-> filt_zone == 3'd2);
  a_r3_cls_zone: assert property (@(posedge clk) disable iff (!rst_n)
    cls_en |-> filt_zone == 3'd4);
  a_r5_pg_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> ($past(filt_zone) == 3'd7 && !$past(hot)));
  a_r5_pg_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_good) |-> ($past(filt_zone) < 3'd6 || $past(hot)));
  a_r7_hot_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(die_temp, 2) > T_SET) |-> !pwr_good);
endmodule

bind pd_line_seq pd_line_seq_chk #(.TW(TW), .T_HOT(T_HOT)) chk_i (
  .clk(clk), .rst_n(rst_n), .die_temp(die_temp), .sig_en(sig_en),
  .cls_en(cls_en), .cls_code(cls_code), .pwr_good(pwr_good),
  .filt_zone(fz), .hot(hot_q));

// File: tb/pd_line_seq_tb_top.sv
module pd_line_seq_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [12:0] port_mv = '0;
  logic [7:0]  die_temp = 8'd25;
  logic [1:0]  class_sel = 2'd0;
  logic        sig_en, cls_en, pwr_good;
  logic [1:0]  cls_code;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pd_line_seq #(.FILT_N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_mv(port_mv), .die_temp(die_temp),
    .class_sel(class_sel), .sig_en(sig_en), .cls_en(cls_en),
    .cls_code(cls_code), .pwr_good(pwr_good));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold(int v);
    port_mv = 13'(v);
    step(2*N + 6);
  endtask

  task automatic t_reset;
    chk("R1 sig_en in reset", sig_en, 0);
    chk("R1 pwr_good in reset", pwr_good, 0);
    rst_n = 1'b1;
    step(3);
    chk("R1 sig_en after reset", sig_en, 0);
    chk("R1 cls_en after reset", cls_en, 0);
    chk("R1 cls_code after reset", cls_code, 0);
    chk("R1 pwr_good after reset", pwr_good, 0);
  endtask

  task automatic t_detect;
    hold(269);  chk("R2 below window", sig_en, 0);
    hold(270);  chk("R2 low edge", sig_en, 1);
    chk("R10 no class in detect", cls_en, 0);
    hold(1010); chk("R2 high edge", sig_en, 1);
    hold(1011); chk("R2 above window", sig_en, 0);
    hold(0);
  endtask

  task automatic t_class;
    class_sel = 2'd2;
    hold(1449); chk("R3 below class window", cls_en, 0);
    hold(1450); chk("R3 low edge", cls_en, 1);
    chk("R4 code captured", cls_code, 2);
    chk("R10 no signature in class", sig_en, 0);
    class_sel = 2'd3;
    hold(2140); chk("R3 high edge", cls_en, 1);
    chk("R4 late class_sel ignored", cls_code, 2);
    hold(2141); chk("R3 above window", cls_en, 0);
    chk("R4 code idle", cls_code, 0);
    hold(1800); chk("R6 re-entry from above", cls_en, 0);
    hold(1050); hold(1800);
    chk("R6 mark dip then class", cls_en, 0);
    chk("R6 code stays 0", cls_code, 0);
    hold(159); hold(1800);
    chk("R8 re-armed after reset level", cls_en, 1);
    chk("R4 new capture", cls_code, 3);
    hold(160); hold(1800);
    chk("R8 160 is not reset level", cls_en, 0);
    hold(0);
  endtask

  task automatic t_power;
    hold(3699); chk("R5 below on level", pwr_good, 0);
    hold(3700); chk("R5 on level", pwr_good, 1);
    chk("R10 sig quiet with pg", sig_en, 0);
    chk("R10 cls quiet with pg", cls_en, 0);
    hold(3200); chk("R5 hysteresis holds", pwr_good, 1);
    hold(3199); chk("R5 off level", pwr_good, 0);
    hold(3500); chk("R5 no re-rise inside band", pwr_good, 0);
    hold(3700); chk("R5 re-rise", pwr_good, 1);
  endtask

  task automatic t_thermal;
    die_temp = 8'd160; step(4); chk("R7 160 not hot", pwr_good, 1);
    die_temp = 8'd161; step(2); chk("R7 over-temp", pwr_good, 0);
    die_temp = 8'd150; step(4); chk("R7 still hot", pwr_good, 0);
    die_temp = 8'd140; step(4); chk("R7 released", pwr_good, 1);
    hold(100); chk("R8 pg drops at reset level", pwr_good, 0);
  endtask

  task automatic t_glitch;
    hold(500);
    port_mv = 13'd100;
    for (int i = 0; i < N-1; i++) begin
      step(1); chk("R9 short dip ignored", sig_en, 1);
    end
    port_mv = 13'd500; step(2*N);
    chk("R9 after short dip", sig_en, 1);
    port_mv = 13'd1800;
    step(N-1); chk("R9 not yet accepted", cls_en, 0);
    chk("R9 detect still on", sig_en, 1);
    step(1);   chk("R9 accepted on Nth sample", cls_en, 1);
    hold(0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    step(3);
    t_reset;
    t_detect;
    t_class;
    t_power;
    t_thermal;
    t_glitch;
    done = 1;
    summary;
    $finish;
  end

  initial begin
    #(CLK_P*100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got 0 expected 1");
      summary;
      $finish;
    end
  end
endmodule